// File: doc/BRIEF.md
# Parallel Host Bus Interface for a Character Display Controller

This block sits between a host's parallel strobe bus and the command core of a character display controller. The whole block runs on one synchronous system clock. It brings the enable strobe, register select, read/write select and the 8-bit data bus into the clock domain. It finds the falling edge of the enable strobe and uses that edge to complete each transfer.

A completed write hands one byte to the core through a one-cycle valid strobe, together with a register-select bit. That bit tells the core whether the byte is a command or display data. A read drives the bus while the enable strobe is high. A status read returns the busy flag with the address counter. A data read returns the prefetched data register. After a data read completes, the block raises a one-cycle request so that the core steps its address and reloads the register.

The bus width is a run-time mode that is changed by a function-set command. In the narrow mode, each byte is moved as two 4-bit halves on the upper four data lines, the high half first. While the core reports busy, every completed transfer other than a status read is dropped.

Top module: `hbus_host_if`

## Requirements
- R1: A write with select low completes on the falling edge of the enable strobe. Exactly 3 clock cycles after that edge reaches the input pin, `wr_valid_o` is high for one cycle, with `wr_rs_o`=0 and `wr_data_o` equal to the byte.
- R2: A write with select high produces the same one-cycle strobe with `wr_rs_o`=1.
- R3: While the enable strobe is high on a read with select low, `db_o` carries the busy input on bit 7 and the 7-bit address counter on bits 6..0. No strobe or request follows.
- R4: While the enable strobe is high on a read with select high, `db_o` carries `dr_i`. 3 cycles after the falling edge, `rd_req_o` is high for one cycle. `wr_valid_o` and `rd_req_o` are never high together.
- R5: `db_oe_o` is high only while the synchronized enable strobe is high and read is selected. It is low during writes and once the strobe is low.
- R6: After reset, the strobe outputs and `db_oe_o` are low and the interface is in 8-bit mode, so one enable cycle moves one byte.
- R7: An accepted command byte with bits 7..5 = 001 and bit 4 (width bit) = 0 selects 4-bit mode from the next transfer. In that mode, bits 7..4 of the first enable cycle form the high half of the byte and bits 7..4 of the second form the low half. The strobe follows only the second cycle.
- R8: In 4-bit mode, a read takes two enable cycles. The first drives the high half of the read word on `db_o[7:4]` and the second drives the low half, with `db_o[3:0]`=0. A data read raises `rd_req_o` only after the second cycle.
- R9: A write or data read that completes while `busy_i`=1 produces neither strobe nor request. In 4-bit mode the half-byte phase still advances.
- R10: An accepted command byte with bits 7..5 = 001 and bit 4 = 1 selects 8-bit mode from the next transfer, starting from a clean byte boundary.
- R11: A width command that completes while `busy_i`=1 leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| e_i | input | 1 | Host enable strobe; the falling edge completes a transfer |
| rs_i | input | 1 | Register select: 0 command/status, 1 data |
| rw_i | input | 1 | 1 read, 0 write |
| db_i | input | 8 | Data bus input |
| db_o | output | 8 | Data bus output value |
| db_oe_o | output | 1 | Data bus output enable |
| busy_i | input | 1 | Core busy flag |
| ac_i | input | 7 | Core address counter |
| dr_i | input | 8 | Core prefetched data register |
| wr_valid_o | output | 1 | One-cycle strobe for a completed byte write |
| wr_rs_o | output | 1 | Register select of the written byte |
| wr_data_o | output | 8 | Written byte |
| rd_req_o | output | 1 | One-cycle request after a completed data read |

## Verification
Each completed transfer produces its strobe or request 3 clock cycles after the enable strobe falls at the pin: two cycles for the synchronizer and one output register. The bench queues every expected event with that exact cycle number and compares both outputs on every falling clock edge, so a missing, extra or late pulse is a mismatch. Read data and output enable follow the synchronized strobe combinationally, 2 cycles after it rises. They are sampled five cycles into each enable pulse. Output enable is checked again six cycles after the pulse ends.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int AC_W   = 7;

  // command byte that sets the bus width: opcode in the top three bits
  localparam logic [2:0] WIDTH_OP     = 3'b001;
  localparam int         WIDTH_OP_LSB = 5;
  localparam int         WIDE_BIT     = 4;

  typedef enum logic {
    PH_HI = 1'b0,
    PH_LO = 1'b1
  } nib_phase_e;

  typedef struct packed {
    logic              e;
    logic              rs;
    logic              rw;
    logic [BYTE_W-1:0] db;
  } bus_smp_t;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (STAGES <= 1) begin : g_single
      logic [W-1:0] stg_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= d_i;
      end
      assign q_o = stg_q;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
      assign q_o = stg_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/hbus_strobe.sv
module hbus_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic e_s_i,
  output logic fall_o
);
  logic e_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) e_d_q <= 1'b0;
    else         e_d_q <= e_s_i;
  end

  assign fall_o = e_d_q & ~e_s_i;

  p_fall_follows_high_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> $past(e_s_i));
endmodule

// File: rtl/hbus_xfer.sv
module hbus_xfer
  import hbus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              rs_i,
  input  logic              rw_i,
  input  logic [BYTE_W-1:0] db_i,
  input  logic              busy_i,
  output logic              mode4_o,
  output nib_phase_e        phase_o,
  output logic              wr_valid_o,
  output logic              wr_rs_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_req_o
);
  logic              mode4_q;
  nib_phase_e        phase_q;
  logic [NIB_W-1:0]  hi_q;
  logic              half_step, byte_done, accept;
  logic              wr_fire, rd_fire, width_cmd, want4;
  logic [BYTE_W-1:0] asm_byte;

  always_comb begin
    half_step = fall_i & mode4_q & (phase_q == PH_HI);
    byte_done = fall_i & (~mode4_q | (phase_q == PH_LO));
    asm_byte  = mode4_q ? {hi_q, db_i[BYTE_W-1 -: NIB_W]} : db_i;
    accept    = byte_done & ~busy_i;
    wr_fire   = accept & ~rw_i;
    rd_fire   = accept & rw_i & rs_i;
    width_cmd = wr_fire & ~rs_i &
                (asm_byte[BYTE_W-1:WIDTH_OP_LSB] == WIDTH_OP);
    want4     = ~asm_byte[WIDE_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode4_q <= 1'b0;
      phase_q <= PH_HI;
      hi_q    <= '0;
    end else begin
      if (half_step) begin
        hi_q    <= db_i[BYTE_W-1 -: NIB_W];
        phase_q <= PH_LO;
      end else if (byte_done) begin
        phase_q <= PH_HI;
      end
      if (width_cmd && (want4 != mode4_q)) begin
        mode4_q <= want4;
        phase_q <= PH_HI;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_o <= 1'b0;
      wr_rs_o    <= 1'b0;
      wr_data_o  <= '0;
      rd_req_o   <= 1'b0;
    end else begin
      wr_valid_o <= wr_fire;
      rd_req_o   <= rd_fire;
      if (wr_fire) begin
        wr_rs_o   <= rs_i;
        wr_data_o <= asm_byte;
      end
    end
  end

  assign mode4_o = mode4_q;
  assign phase_o = phase_q;

  p_busy_drops_wr_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> !$past(busy_i));
  p_busy_drops_rd_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> !$past(busy_i));
  p_hi_after_byte_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done |=> phase_q == PH_HI);
  p_mode_switch_clean_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode4_q != $past(mode4_q)) |-> phase_q == PH_HI);
  p_req_single_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
  p_no_overlap_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_valid_o && rd_req_o));
endmodule

// File: rtl/hbus_readmux.sv
module hbus_readmux
  import hbus_pkg::*;
(
  input  logic              e_s_i,
  input  logic              rs_i,
  input  logic              rw_i,
  input  logic              mode4_i,
  input  nib_phase_e        phase_i,
  input  logic              busy_i,
  input  logic [AC_W-1:0]   ac_i,
  input  logic [BYTE_W-1:0] dr_i,
  output logic [BYTE_W-1:0] db_o,
  output logic              db_oe_o
);
  logic [BYTE_W-1:0] word;
  logic [NIB_W-1:0]  half;

  always_comb begin
    word = rs_i ? dr_i : {busy_i, ac_i};
    half = (phase_i == PH_LO) ? word[NIB_W-1:0] : word[BYTE_W-1 -: NIB_W];
    db_o = mode4_i ? {half, {NIB_W{1'b0}}} : word;
    db_oe_o = e_s_i & rw_i;
  end
endmodule

// File: rtl/hbus_host_if.sv
module hbus_host_if
  import hbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              e_i,
  input  logic              rs_i,
  input  logic              rw_i,
  input  logic [BYTE_W-1:0] db_i,
  output logic [BYTE_W-1:0] db_o,
  output logic              db_oe_o,
  input  logic              busy_i,
  input  logic [AC_W-1:0]   ac_i,
  input  logic [BYTE_W-1:0] dr_i,
  output logic              wr_valid_o,
  output logic              wr_rs_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_req_o
);
  localparam int SMP_W = $bits(bus_smp_t);

  bus_smp_t   raw, smp;
  logic       e_fall, mode4;
  nib_phase_e phase;

  assign raw = '{e: e_i, rs: rs_i, rw: rw_i, db: db_i};

  hbus_sync #(.W(SMP_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (smp)
  );

  hbus_strobe u_strobe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .e_s_i (smp.e),
    .fall_o(e_fall)
  );

  hbus_xfer u_xfer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fall_i    (e_fall),
    .rs_i      (smp.rs),
    .rw_i      (smp.rw),
    .db_i      (smp.db),
    .busy_i    (busy_i),
    .mode4_o   (mode4),
    .phase_o   (phase),
    .wr_valid_o(wr_valid_o),
    .wr_rs_o   (wr_rs_o),
    .wr_data_o (wr_data_o),
    .rd_req_o  (rd_req_o)
  );

  hbus_readmux u_rmux (
    .e_s_i  (smp.e),
    .rs_i   (smp.rs),
    .rw_i   (smp.rw),
    .mode4_i(mode4),
    .phase_i(phase),
    .busy_i (busy_i),
    .ac_i   (ac_i),
    .dr_i   (dr_i),
    .db_o   (db_o),
    .db_oe_o(db_oe_o)
  );

  p_strobe_after_fall_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> $past(e_fall));
  p_req_after_fall_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> $past(e_fall));
  p_no_drive_on_strobe_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    e_fall |-> !db_oe_o);
endmodule

// File: tb/tb_hbus_host_if.sv
module tb_hbus_host_if;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       e_i = 1'b0, rs_i = 1'b0, rw_i = 1'b0;
  logic [7:0] db_i = 8'h00;
  logic [7:0] db_o;
  logic       db_oe_o;
  logic       busy_i = 1'b0;
  logic [6:0] ac_i = 7'h00;
  logic [7:0] dr_i = 8'h00;
  logic       wr_valid_o, wr_rs_o, rd_req_o;
  logic [7:0] wr_data_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit run = 1'b0;

  // reference model state
  bit         m_mode4 = 1'b0, m_lo = 1'b0;
  logic [3:0] m_hi = 4'h0;
  int         q_cyc[$];
  bit         q_rd[$], q_rs[$];
  logic [7:0] q_dat[$];
  string      q_tag[$];

  hbus_host_if dut (
    .clk_i(clk), .rst_ni(rst_ni), .e_i(e_i), .rs_i(rs_i), .rw_i(rw_i),
    .db_i(db_i), .db_o(db_o), .db_oe_o(db_oe_o), .busy_i(busy_i),
    .ac_i(ac_i), .dr_i(dr_i), .wr_valid_o(wr_valid_o), .wr_rs_o(wr_rs_o),
    .wr_data_o(wr_data_o), .rd_req_o(rd_req_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [7:0] act,
                     input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-clock comparison of strobes against queued expectations
  always @(negedge clk) begin
    if (run) begin
      if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
        if (q_rd[0])
          chk(rd_req_o && !wr_valid_o, q_tag[0], {6'b0, wr_valid_o, rd_req_o}, 8'h01);
        else begin
          chk(wr_valid_o && !rd_req_o && wr_rs_o == q_rs[0], q_tag[0],
              {5'b0, wr_rs_o, wr_valid_o, rd_req_o}, {5'b0, q_rs[0], 2'b10});
          chk(wr_data_o == q_dat[0], q_tag[0], wr_data_o, q_dat[0]);
        end
        void'(q_cyc.pop_front()); void'(q_rd.pop_front()); void'(q_rs.pop_front());
        void'(q_dat.pop_front()); void'(q_tag.pop_front());
      end else begin
        chk(!wr_valid_o && !rd_req_o, "R9 no unexpected strobe",
            {6'b0, wr_valid_o, rd_req_o}, 8'h00);
      end
    end
  end

  task automatic xfer(input bit rs, input bit rw, input logic [7:0] d, input string tag);
    logic [7:0] word, exp;
    int k;
    @(negedge clk);
    rs_i = rs; rw_i = rw; db_i = d;
    repeat (3) @(negedge clk);
    e_i = 1'b1;
    repeat (5) @(negedge clk);
    chk(db_oe_o == rw, {"R5 oe while high / ", tag}, {7'b0, db_oe_o}, {7'b0, rw});
    if (rw) begin
      word = rs ? dr_i : {busy_i, ac_i};
      if (m_mode4) exp = m_lo ? {word[3:0], 4'h0} : {word[7:4], 4'h0};
      else         exp = word;
      chk(db_o == exp, tag, db_o, exp);
    end
    e_i = 1'b0;
    k = cyc;
    if (m_mode4 && !m_lo) begin
      m_hi = d[7:4];
      m_lo = 1'b1;
    end else begin
      word = m_mode4 ? {m_hi, d[7:4]} : d;
      m_lo = 1'b0;
      if (!busy_i) begin
        if (!rw || rs) begin
          q_cyc.push_back(k + 3); q_rd.push_back(rw); q_rs.push_back(rs);
          q_dat.push_back(word); q_tag.push_back(tag);
        end
        if (!rw && !rs && word[7:5] == 3'b001) m_mode4 = !word[4];
      end
    end
    repeat (6) @(negedge clk);
    chk(!db_oe_o, {"R5 oe after low / ", tag}, {7'b0, db_oe_o}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!db_oe_o && !wr_valid_o && !rd_req_o, "R6 reset outputs",
        {5'b0, db_oe_o, wr_valid_o, rd_req_o}, 8'h00);
    run = 1'b1;

    // 8-bit mode
    xfer(0, 0, 8'h01, "R6 R1 single-cycle command byte");
    xfer(1, 0, 8'hA5, "R2 data write");
    ac_i = 7'h35;
    xfer(0, 1, 8'h00, "R3 status idle");
    busy_i = 1'b1; ac_i = 7'h12;
    xfer(0, 1, 8'h00, "R3 status busy");
    busy_i = 1'b0; dr_i = 8'h5C;
    xfer(1, 1, 8'h00, "R4 data read");
    busy_i = 1'b1;
    xfer(0, 0, 8'h3C, "R9 busy command dropped");
    xfer(1, 1, 8'h00, "R9 busy data read");
    xfer(0, 0, 8'h20, "R11 busy width command");
    busy_i = 1'b0;
    xfer(1, 0, 8'h77, "R11 still 8-bit");

    // switch to 4-bit mode
    xfer(0, 0, 8'h28, "R7 width command");
    xfer(0, 0, 8'h0F, "R7 hi half");
    xfer(0, 0, 8'hFF, "R7 command byte 0F");
    xfer(1, 0, 8'hCF, "R7 hi half data");
    xfer(1, 0, 8'h3F, "R7 data byte C3");
    busy_i = 1'b1; ac_i = 7'h5A;
    xfer(0, 1, 8'h00, "R8 status hi half");
    xfer(0, 1, 8'h00, "R8 status lo half");
    busy_i = 1'b0; dr_i = 8'h96;
    xfer(1, 1, 8'h00, "R8 data read hi half");
    xfer(1, 1, 8'h00, "R8 data read lo half");
    busy_i = 1'b1;
    xfer(1, 0, 8'h4F, "R9 busy hi half");
    xfer(1, 0, 8'h4F, "R9 busy lo half");
    busy_i = 1'b0;
    xfer(1, 0, 8'hBF, "R9 phase advanced hi");
    xfer(1, 0, 8'h2F, "R9 phase advanced byte B2");

    // back to 8-bit mode
    xfer(0, 0, 8'h3F, "R10 width hi half");
    xfer(0, 0, 8'h0F, "R10 width lo half");
    xfer(1, 0, 8'hE7, "R10 single-cycle byte");
    dr_i = 8'h81;
    xfer(1, 1, 8'h00, "R10 R4 8-bit read");

    repeat (4) @(negedge clk);
    chk(q_cyc.size() == 0, "R1 all expected strobes seen", 8'(q_cyc.size()), 8'h00);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule